// File: doc/BRIEF.md
# Right-Justified Auxiliary DAC Serializer

This block feeds two additional stereo DAC data lines, for surround output, from a bit clock supplied by another device. It derives its own left/right framing clock from that bit clock and sends one 16-bit sample per channel slot on both lines at once, right justified in a 32-bit slot and most significant bit first. All outputs change on falling bit-clock edges so that the receiving DACs can sample them on the rising edge.

Software or an upstream mixer presents four sample words, a left and a right word for each line, and strobes a load input. The words are held in a pending bank and moved into the active bank at the next frame boundary, so a frame is never made of a mix of old and new words. A sample request output pulses once per frame to ask for the next set. If nothing is loaded, the last words are sent again. The companion DACs run their master clock at 384 times the frame rate, which is 6 master clocks per bit clock; the block itself needs only the bit clock.

Top module: `aux_dac_serializer`

## Requirements
- R1: The framing clock, both data lines and the sample request change only on falling edges of `bclk_i`; they hold steady across each rising edge.
- R2: A frame is 64 bit periods. Counting the bit period after reset release as count 0, `lrclk_o` is high (left) for counts 0 to 31 and low (right) for counts 32 to 63.
- R3: In each 32-bit channel slot, the first 16 bit periods carry zero on every data line.
- R4: The last 16 bit periods of a slot carry the sample, MSB first. Line L sends word 2L (bits [32L+15:32L] of `smp_i`) in the left slot and word 2L+1 (bits [32L+31:32L+16]) in the right slot.
- R5: Both data lines use the same bit position at all times: bit n of each line's slot appears in the same bit period.
- R6: `req_o` is high for exactly one bit period per frame, the period of count 0, and is low during the first frame after reset.
- R7: Words on `smp_i` sampled on a falling edge with `load_i` high are sent starting at the next frame boundary; a load sampled on the very edge that starts a frame is sent from the following frame.
- R8: When no load occurs during a frame, the next frame repeats the previous words.
- R9: During reset `lrclk_o` is high, the data lines and `req_o` are low, and the active words are zero, so the first frame after reset is silent.
- R10: When several loads occur within one frame, the last one is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock from the external codec; the block acts on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture the words on `smp_i` into the pending bank |
| smp_i | input | 64 | Four 16-bit words, index 2*line + channel (channel 0 left, 1 right) |
| lrclk_o | output | 1 | Framing clock, high during the left slot |
| sdata_o | output | 2 | Serial data, one bit per auxiliary DAC line |
| req_o | output | 1 | One-bit-period pulse at the start of each frame requesting new words |

## Verification
The bench goes after a load that lands on the frame-starting edge itself, where a design that moves pending words one edge late or early would start a frame with the wrong sample or mix two sets within one frame. It loads twice in one frame and then skips loading, catching a bank that keeps the first load or clears to zero instead of repeating. Words with the MSB and LSB set, with alternating bits and with distinct values per line expose an off-by-one slot offset, a reversed bit order, swapped channels or lines drifting apart. Outputs are also sampled just before each falling edge to catch any change made on the rising edge.

// File: rtl/aux_dac_pkg.sv
package aux_dac_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // word index inside the flat sample bus
  function automatic int word_idx(input int line, input chan_e ch);
    return line * 2 + int'(ch);
  endfunction

endpackage

// File: rtl/aux_frame_cnt.sv
module aux_frame_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             bclk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o,
  output logic             lrclk_o,
  output logic             req_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             lrclk_q;
  logic             req_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);
  assign wrap_o    = (cnt_nxt_o == '0);

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lrclk_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt_o;
      lrclk_q <= ~cnt_nxt_o[CNT_W-1];
      req_q   <= wrap_o;
    end
  end

  assign cnt_o   = cnt_q;
  assign lrclk_o = lrclk_q;
  assign req_o   = req_q;

endmodule

// File: rtl/aux_word_bank.sv
module aux_word_bank #(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_WORDS = 4
) (
  input  logic                          bclk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic                          wrap_i,
  input  logic [NUM_WORDS*SAMPLE_W-1:0] smp_i,
  output logic [NUM_WORDS*SAMPLE_W-1:0] act_o
);

  logic [NUM_WORDS*SAMPLE_W-1:0] pend_q;
  logic [NUM_WORDS*SAMPLE_W-1:0] act_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(negedge bclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[w*SAMPLE_W +: SAMPLE_W] <= '0;
        act_q[w*SAMPLE_W +: SAMPLE_W]  <= '0;
      end else begin
        if (load_i) pend_q[w*SAMPLE_W +: SAMPLE_W] <= smp_i[w*SAMPLE_W +: SAMPLE_W];
        // active bank takes the pending value from before this edge
        if (wrap_i) act_q[w*SAMPLE_W +: SAMPLE_W] <= pend_q[w*SAMPLE_W +: SAMPLE_W];
      end
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/aux_slot_shifter.sv
module aux_slot_shifter
  import aux_dac_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  parameter int CNT_W    = 6
) (
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    cnt_nxt_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sd_o
);

  localparam int POS_W = CNT_W - 1;
  localparam int PAD_W = SLOT_W - SAMPLE_W;
  localparam logic [POS_W-1:0] FIRST_POS = POS_W'(PAD_W);

  logic [POS_W-1:0]    pos;
  chan_e               half;
  logic                first_bit;
  logic                data_ph;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] sh_q;
  logic                sd_q;

  assign pos       = cnt_nxt_i[POS_W-1:0];
  assign half      = chan_e'(cnt_nxt_i[CNT_W-1]);
  assign first_bit = (pos == FIRST_POS);
  assign data_ph   = (pos >= FIRST_POS);
  assign word      = (half == CH_LEFT) ? left_i : right_i;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else if (first_bit) begin
      sd_q <= word[SAMPLE_W-1];
      sh_q <= {word[SAMPLE_W-2:0], 1'b0};
    end else if (data_ph) begin
      sd_q <= sh_q[SAMPLE_W-1];
      sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
    end else begin
      sd_q <= 1'b0;
    end
  end

  assign sd_o = sd_q;

endmodule

// File: rtl/aux_dac_serializer.sv
module aux_dac_serializer
  import aux_dac_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_W    = 32,
  parameter int NUM_LINES = 2
) (
  input  logic                            bclk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [2*NUM_LINES*SAMPLE_W-1:0] smp_i,
  output logic                            lrclk_o,
  output logic [NUM_LINES-1:0]            sdata_o,
  output logic                            req_o
);

  // SLOT_W must be a power of two, SAMPLE_W <= SLOT_W
  localparam int CNT_W     = $clog2(2 * SLOT_W);
  localparam int NUM_WORDS = 2 * NUM_LINES;

  logic [CNT_W-1:0]              cnt_q;
  logic [CNT_W-1:0]              cnt_nxt;
  logic                          wrap;
  logic [NUM_WORDS*SAMPLE_W-1:0] act_w;

  aux_frame_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .bclk_i   (bclk_i),
    .rst_ni   (rst_ni),
    .cnt_o    (cnt_q),
    .cnt_nxt_o(cnt_nxt),
    .wrap_o   (wrap),
    .lrclk_o  (lrclk_o),
    .req_o    (req_o)
  );

  aux_word_bank #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_WORDS(NUM_WORDS)
  ) u_bank (
    .bclk_i(bclk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .wrap_i(wrap),
    .smp_i (smp_i),
    .act_o (act_w)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam int WL = 2 * l;
    localparam int WR = 2 * l + 1;
    aux_slot_shifter #(
      .SAMPLE_W(SAMPLE_W),
      .SLOT_W  (SLOT_W),
      .CNT_W   (CNT_W)
    ) u_shf (
      .bclk_i   (bclk_i),
      .rst_ni   (rst_ni),
      .cnt_nxt_i(cnt_nxt),
      .left_i   (act_w[WL*SAMPLE_W +: SAMPLE_W]),
      .right_i  (act_w[WR*SAMPLE_W +: SAMPLE_W]),
      .sd_o     (sdata_o[l])
    );
  end

endmodule

// File: rtl/aux_dac_serializer_chk.sv
module aux_dac_serializer_chk #(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_W    = 32,
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 6
) (
  input logic                 bclk_i,
  input logic                 rst_ni,
  input logic [CNT_W-1:0]     cnt_i,
  input logic                 lrclk_i,
  input logic                 req_i,
  input logic [NUM_LINES-1:0] sd_i
);

  localparam int PAD_W = SLOT_W - SAMPLE_W;

  logic armed_q;
  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_cnt_step_r2: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    armed_q |-> ((cnt_i - $past(cnt_i)) == CNT_W'(1)));

  p_lr_edge_r2: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    !$stable(lrclk_i) |-> (cnt_i[CNT_W-2:0] == '0));

  p_pad_zero_r3: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    (int'(cnt_i[CNT_W-2:0]) < PAD_W) |-> (sd_i == '0));

  p_req_left_r6: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    req_i |-> (lrclk_i && cnt_i == '0));

  p_req_once_r6: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    req_i |=> !req_i);

endmodule

bind aux_dac_serializer aux_dac_serializer_chk #(
  .SAMPLE_W (SAMPLE_W),
  .SLOT_W   (SLOT_W),
  .NUM_LINES(NUM_LINES),
  .CNT_W    (CNT_W)
) u_chk (
  .bclk_i (bclk_i),
  .rst_ni (rst_ni),
  .cnt_i  (cnt_q),
  .lrclk_i(lrclk_o),
  .req_i  (req_o),
  .sd_i   (sdata_o)
);

// File: tb/aux_dac_serializer_test.sv
module aux_dac_serializer_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW    = 16;
  localparam int SLOT  = 32;
  localparam int FRAME = 2 * SLOT;
  localparam int NL    = 2;
  localparam int BW    = 2 * NL * SW;

  logic          bclk = 1'b1;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [BW-1:0] smp = '0;
  logic          lrclk;
  logic [NL-1:0] sdata;
  logic          req;

  int n_chk = 0;
  int n_bad = 0;
  int edge_n = 0;
  bit done = 0;

  typedef struct {
    int            frame;
    logic [BW-1:0] w;
  } exp_t;
  exp_t exp_q[$];
  logic [BW-1:0] cur = '0;
  logic [BW-1:0] rx  = '0;

  aux_dac_serializer uut (
    .bclk_i (bclk),
    .rst_ni (rst_n),
    .load_i (load),
    .smp_i  (smp),
    .lrclk_o(lrclk),
    .sdata_o(sdata),
    .req_o  (req)
  );

  always #(CLK_PERIOD/2) bclk = ~bclk;

  always @(negedge bclk) if (rst_n) edge_n++;

  task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act,
                     input logic [BW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %h expected %h", tag, edge_n, act, expv);
    end
  endtask

  // driver: call in a rising-edge timestep; load sampled on the next falling edge
  task automatic drive_load(input logic [BW-1:0] w);
    exp_t e;
    e.frame = (edge_n + 1) / FRAME + 1;
    e.w     = w;
    exp_q.push_back(e);
    smp  = w;
    load = 1'b1;
    @(posedge bclk);
    load = 1'b0;
    smp  = ~w;
  endtask

  task automatic wait_edge(input int n);
    while (edge_n != n) @(posedge bclk);
  endtask

  // monitor
  always @(posedge bclk) begin
    if (rst_n && edge_n >= 1 && !done) begin
      int k, c, p, ch, f;
      logic e_lr, e_req;
      logic [NL-1:0] e_sd;
      logic s_lr, s_req;
      logic [NL-1:0] s_sd;
      k  = edge_n;
      c  = k % FRAME;
      p  = c % SLOT;
      ch = c / SLOT;
      f  = k / FRAME;
      if (c == 0) begin
        while (exp_q.size() > 0 && exp_q[0].frame <= f) cur = exp_q.pop_front().w;
        rx = '0;
      end
      e_lr  = (c < SLOT);
      e_req = (c == 0);
      for (int l = 0; l < NL; l++)
        e_sd[l] = (p < SLOT - SW) ? 1'b0 : cur[(2*l+ch)*SW + (SLOT-1-p)];
      chk(lrclk == e_lr, "R2 lrclk", BW'(lrclk), BW'(e_lr));
      chk(req == e_req, "R6 req", BW'(req), BW'(e_req));
      if (p < SLOT - SW) chk(sdata == e_sd, "R3 pad", BW'(sdata), BW'(e_sd));
      else               chk(sdata == e_sd, "R4 R5 data", BW'(sdata), BW'(e_sd));
      if (p >= SLOT - SW)
        for (int l = 0; l < NL; l++) rx[(2*l+ch)*SW + (SLOT-1-p)] = sdata[l];
      if (c == FRAME - 1)
        chk(rx == cur, "R7 R8 R10 frame words", rx, cur);
      s_lr = lrclk; s_req = req; s_sd = sdata;
      #(CLK_PERIOD/4);
      chk({s_lr, s_req, s_sd} == {lrclk, req, sdata}, "R1 hold before falling edge",
          BW'({lrclk, req, sdata}), BW'({s_lr, s_req, s_sd}));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge bclk);
    // R9: reset state
    chk(lrclk == 1'b1, "R9 reset lrclk", BW'(lrclk), BW'(1));
    chk(sdata == '0,   "R9 reset data",  BW'(sdata), '0);
    chk(req == 1'b0,   "R9 reset req",   BW'(req),   '0);
    rst_n = 1'b1;
    // frame 0 stays silent (R9); A goes to frame 1
    wait_edge(10);
    drive_load(64'h8001_7FFE_A5A5_0001);
    // two loads in frame 1: last wins in frame 2 (R10)
    wait_edge(70);
    drive_load(64'h1234_5678_9ABC_DEF0);
    wait_edge(100);
    drive_load(64'hFFFF_0000_5555_C003);
    // frame 3: no load, frame 2 words repeat (R8)
    // load sampled on the frame-3 start edge: sent from frame 4 (R7)
    wait_edge(FRAME * 3 - 1);
    drive_load(64'h0F0F_F0F0_8000_0001);
    // load on the last edge before a boundary: sent from frame 5 (R7)
    wait_edge(FRAME * 5 - 2);
    drive_load(64'hAAAA_5555_FFFF_7FFF);
    // frame 6 and 7: repeats (R8)
    wait_edge(FRAME * 8 + 2);
    done = 1;
    @(posedge bclk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule